// File: doc/BRIEF.md
# Function Hotplug Event Manager

This block tracks a small set of function slots. Each slot holds a function ID, a function handle, a configured flag and a valid marker. It reacts to four kinds of request: plugging a function into a slot, unplugging it, reporting an error against it, and configure or deconfigure commands addressed by function ID. Plug and unplug transitions, as well as error reports, become coded events. These events are written into a pending-event queue. Each cycle that queues at least one event raises a notification pulse toward the host.

Software drains the queue through a pop port. One cycle after a pop, the port returns the event class, the event code, the handle, the function ID, a fault address and a qualifier word. If the queue was empty, it reports that no event was available instead.

Three combinational lookup ports search the valid slots: one by function ID, one by handle, and one that finds the n-th valid slot in slot order.

Top module: `fn_hotplug_mgr`

## Requirements
- R1: Plugging slot N makes that slot valid and configured, with function ID N and handle N OR 0x00FF0000; the lookup ports then find the slot.
- R2: A plug queues two events of class 2 that carry the new handle and ID: code 0x0302 first, then code 0x0301.
- R3: An unplug queues code 0x0304 only if the slot is configured, then always code 0x0308, both of class 2 and carrying the old handle and ID; afterwards the slot is invalid and no lookup finds it.
- R4: An error request queues one event of class 1 that carries the supplied code, the slot's handle and ID, the 64-bit fault address and the 32-bit qualifier.
- R5: A configure (cfg_on=1) or deconfigure (cfg_on=0) command answers one cycle later with cfg_resp_vld high and one of three codes. 0x0030 means no valid slot holds the ID. 0x0020 means the slot is already in the requested state. 0x0010 means normal completion, and in that case the configured flag is flipped. The command queues no event.
- R6: Events leave in arrival order. A pop returns rd_vld and the head event one cycle later. A pop on an empty queue returns rd_none instead. `pending` is high exactly while the queue holds an event.
- R7: `notify` is high for the one cycle that follows any cycle in which at least one event entered the queue.
- R8: An event that finds the queue full is dropped; `overflow` then rises and stays high until reset. Of a two-event pair, the first event can be accepted while the second is dropped.
- R9: The index lookup returns the k-th valid slot, counting from slot 0 upward. It misses when fewer than k+1 slots are valid. The ID and handle lookups match valid slots only.
- R10: Only one request acts per cycle, with priority plug, then unplug, then error, then configure. A lower-priority request raised in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plug_req | input | 1 | Plug a function into req_slot |
| unplug_req | input | 1 | Unplug the function in req_slot |
| err_req | input | 1 | Report an error against req_slot |
| req_slot | input | $clog2(NUM_SLOTS) | Slot addressed by plug, unplug and error |
| err_code | input | 16 | Error event code |
| err_addr | input | 64 | Fault address for the error event |
| err_qual | input | 32 | Qualifier word for the error event |
| cfg_req | input | 1 | Configure or deconfigure command |
| cfg_on | input | 1 | 1 = configure, 0 = deconfigure |
| cfg_id | input | 32 | Function ID targeted by the command |
| cfg_resp_vld | output | 1 | Response valid, one cycle after the command |
| cfg_resp | output | 16 | Response code |
| lk_id | input | 32 | Function ID to look up |
| lk_id_hit | output | 1 | A valid slot holds lk_id |
| lk_id_slot | output | $clog2(NUM_SLOTS) | Lowest such slot |
| lk_hdl | input | 32 | Handle to look up |
| lk_hdl_hit | output | 1 | A valid slot holds lk_hdl |
| lk_hdl_slot | output | $clog2(NUM_SLOTS) | Lowest such slot |
| lk_idx | input | $clog2(NUM_SLOTS) | Rank among valid slots |
| lk_idx_hit | output | 1 | That many valid slots exist |
| lk_idx_slot | output | $clog2(NUM_SLOTS) | Slot of that rank |
| pop_req | input | 1 | Remove the head event |
| rd_vld | output | 1 | Popped event is on the rd_* outputs |
| rd_none | output | 1 | The pop found the queue empty |
| rd_class | output | 8 | Event class (1 error, 2 availability) |
| rd_code | output | 16 | Event code |
| rd_hdl | output | 32 | Handle carried by the event |
| rd_id | output | 32 | Function ID carried by the event |
| rd_addr | output | 64 | Fault address (0 for availability) |
| rd_qual | output | 32 | Qualifier (0 for availability) |
| pending | output | 1 | Queue is not empty |
| overflow | output | 1 | Sticky: an event was dropped |
| notify | output | 1 | One-cycle pulse after events are queued |

## Verification
The bench builds the block with NUM_SLOTS=4 and FIFO_DEPTH=4. Four slots are enough to leave gaps, so the rank lookup can skip an empty slot and run off the end of the valid set. A four-entry queue can be filled with three error events followed by an unplug of a configured slot. The unplug's first event is then accepted while its second is dropped, so both the partial-acceptance case and the sticky overflow flag can be reached in a handful of cycles.

// File: rtl/fhm_pkg.sv
package fhm_pkg;

  typedef struct packed {
    logic [7:0]  cls;
    logic [15:0] code;
    logic [31:0] hdl;
    logic [31:0] fn_id;
    logic [63:0] addr;
    logic [31:0] qual;
  } fhm_event_t;

  localparam logic [7:0]  CLS_ERROR = 8'd1;
  localparam logic [7:0]  CLS_AVAIL = 8'd2;

  localparam logic [15:0] EVC_ONLINE      = 16'h0301;
  localparam logic [15:0] EVC_ARRIVE      = 16'h0302;
  localparam logic [15:0] EVC_GO_STANDBY  = 16'h0304;
  localparam logic [15:0] EVC_DEPART      = 16'h0308;

  localparam logic [15:0] RSP_DONE    = 16'h0010;
  localparam logic [15:0] RSP_NOOP    = 16'h0020;
  localparam logic [15:0] RSP_UNKNOWN = 16'h0030;

  localparam logic [31:0] HDL_TAG = 32'h00FF_0000;

  function automatic logic [31:0] make_handle(input logic [31:0] slot);
    return HDL_TAG | slot;
  endfunction

  function automatic fhm_event_t mk_event(input logic [7:0] cls, input logic [15:0] code,
                                          input logic [31:0] hdl, input logic [31:0] fn_id,
                                          input logic [63:0] addr, input logic [31:0] qual);
    fhm_event_t e;
    e.cls = cls; e.code = code; e.hdl = hdl; e.fn_id = fn_id; e.addr = addr; e.qual = qual;
    return e;
  endfunction

endpackage

// File: rtl/fhm_slot_table.sv
module fhm_slot_table
  import fhm_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          plug_en,
  input  logic          unplug_en,
  input  logic          cfg_en,
  input  logic [SW-1:0] slot_sel,
  input  logic          cfg_on,
  input  logic [31:0]   cfg_id,
  output logic [31:0]   sel_hdl,
  output logic [31:0]   sel_id,
  output logic          sel_cfg,
  output logic          resp_vld,
  output logic [15:0]   resp,
  input  logic [31:0]   lk_id,
  output logic          lk_id_hit,
  output logic [SW-1:0] lk_id_slot,
  input  logic [31:0]   lk_hdl,
  output logic          lk_hdl_hit,
  output logic [SW-1:0] lk_hdl_slot,
  input  logic [SW-1:0] lk_idx,
  output logic          lk_idx_hit,
  output logic [SW-1:0] lk_idx_slot
);

  logic [31:0]          id_q  [NUM_SLOTS];
  logic [31:0]          hdl_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cfg_q, vld_q;
  logic [NUM_SLOTS-1:0] m_lk_id, m_lk_hdl, m_cmd;
  logic                 cmd_hit;
  logic [SW-1:0]        cmd_slot;

  function automatic logic [SW:0] first_hit(input logic [NUM_SLOTS-1:0] m);
    logic [SW:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (m[i]) r = {1'b1, SW'(i)};
    return r;
  endfunction

  function automatic logic [SW:0] nth_hit(input logic [NUM_SLOTS-1:0] m, input logic [SW-1:0] k);
    logic [SW:0] r;
    int seen;
    r = '0;
    seen = 0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (m[i]) begin
        if (!r[SW] && seen == int'(k)) r = {1'b1, SW'(i)};
        seen++;
      end
    end
    return r;
  endfunction

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
    assign m_lk_id[g]  = vld_q[g] && (id_q[g] == lk_id);
    assign m_lk_hdl[g] = vld_q[g] && (hdl_q[g] == lk_hdl);
    assign m_cmd[g]    = vld_q[g] && (id_q[g] == cfg_id);
  end

  assign {lk_id_hit, lk_id_slot}   = first_hit(m_lk_id);
  assign {lk_hdl_hit, lk_hdl_slot} = first_hit(m_lk_hdl);
  assign {cmd_hit, cmd_slot}       = first_hit(m_cmd);
  assign {lk_idx_hit, lk_idx_slot} = nth_hit(vld_q, lk_idx);

  assign sel_hdl = hdl_q[slot_sel];
  assign sel_id  = id_q[slot_sel];
  assign sel_cfg = cfg_q[slot_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        id_q[i]  <= '0;
        hdl_q[i] <= '0;
      end
      cfg_q    <= '0;
      vld_q    <= '0;
      resp_vld <= 1'b0;
      resp     <= '0;
    end else begin
      resp_vld <= 1'b0;
      if (plug_en) begin
        id_q[slot_sel]  <= 32'(slot_sel);
        hdl_q[slot_sel] <= make_handle(32'(slot_sel));
        cfg_q[slot_sel] <= 1'b1;
        vld_q[slot_sel] <= 1'b1;
      end else if (unplug_en) begin
        id_q[slot_sel]  <= '0;
        hdl_q[slot_sel] <= '0;
        cfg_q[slot_sel] <= 1'b0;
        vld_q[slot_sel] <= 1'b0;
      end else if (cfg_en) begin
        resp_vld <= 1'b1;
        if (!cmd_hit) begin
          resp <= RSP_UNKNOWN;
        end else if (cfg_q[cmd_slot] == cfg_on) begin
          resp <= RSP_NOOP;
        end else begin
          cfg_q[cmd_slot] <= cfg_on;
          resp <= RSP_DONE;
        end
      end
    end
  end

  AST_PLUG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    plug_en |=> (vld_q[$past(slot_sel)] && cfg_q[$past(slot_sel)])); // R1
  AST_UNPLUG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (unplug_en && !plug_en) |=> !vld_q[$past(slot_sel)]); // R3
  AST_RESP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> (resp == RSP_DONE || resp == RSP_NOOP || resp == RSP_UNKNOWN)); // R5

endmodule

// File: rtl/fhm_event_fifo.sv
module fhm_event_fifo
  import fhm_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_a,
  input  fhm_event_t ev_a,
  input  logic       push_b,
  input  fhm_event_t ev_b,
  input  logic       pop,
  output logic       rd_vld,
  output logic       rd_none,
  output fhm_event_t rd_ev,
  output logic       pending,
  output logic       overflow,
  output logic       notify
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  fhm_event_t    mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] wp_q, rp_q;
  logic          acc_a, acc_b, pop_ok;

  assign acc_a   = push_a && (cnt_q < CW'(DEPTH));
  assign acc_b   = push_b && ((cnt_q + CW'(acc_a)) < CW'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign pending = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (acc_a) mem_q[wp_q] <= ev_a;
    if (acc_b) mem_q[wp_q + AW'(acc_a)] <= ev_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      wp_q     <= '0;
      rp_q     <= '0;
      rd_vld   <= 1'b0;
      rd_none  <= 1'b0;
      rd_ev    <= '0;
      overflow <= 1'b0;
      notify   <= 1'b0;
    end else begin
      wp_q     <= wp_q + AW'(acc_a) + AW'(acc_b);
      cnt_q    <= cnt_q + CW'(acc_a) + CW'(acc_b) - CW'(pop_ok);
      rd_vld   <= pop_ok;
      rd_none  <= pop && !pop_ok;
      overflow <= overflow | (push_a && !acc_a) | (push_b && !acc_b);
      notify   <= acc_a | acc_b;
      if (pop_ok) begin
        rd_ev <= mem_q[rp_q];
        rp_q  <= rp_q + 1'b1;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none |-> $past(!pending)); // R6
  AST_NOTIFY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> pending); // R7

endmodule

// File: rtl/fn_hotplug_mgr.sv
module fn_hotplug_mgr
  import fhm_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         plug_req,
  input  logic                         unplug_req,
  input  logic                         err_req,
  input  logic [$clog2(NUM_SLOTS)-1:0] req_slot,
  input  logic [15:0]                  err_code,
  input  logic [63:0]                  err_addr,
  input  logic [31:0]                  err_qual,
  input  logic                         cfg_req,
  input  logic                         cfg_on,
  input  logic [31:0]                  cfg_id,
  output logic                         cfg_resp_vld,
  output logic [15:0]                  cfg_resp,
  input  logic [31:0]                  lk_id,
  output logic                         lk_id_hit,
  output logic [$clog2(NUM_SLOTS)-1:0] lk_id_slot,
  input  logic [31:0]                  lk_hdl,
  output logic                         lk_hdl_hit,
  output logic [$clog2(NUM_SLOTS)-1:0] lk_hdl_slot,
  input  logic [$clog2(NUM_SLOTS)-1:0] lk_idx,
  output logic                         lk_idx_hit,
  output logic [$clog2(NUM_SLOTS)-1:0] lk_idx_slot,
  input  logic                         pop_req,
  output logic                         rd_vld,
  output logic                         rd_none,
  output logic [7:0]                   rd_class,
  output logic [15:0]                  rd_code,
  output logic [31:0]                  rd_hdl,
  output logic [31:0]                  rd_id,
  output logic [63:0]                  rd_addr,
  output logic [31:0]                  rd_qual,
  output logic                         pending,
  output logic                         overflow,
  output logic                         notify
);

  localparam int SW = $clog2(NUM_SLOTS);

  logic        do_plug, do_unplug, do_err, do_cfg;
  logic [31:0] sel_hdl, sel_id;
  logic        sel_cfg;
  logic        push_a, push_b;
  fhm_event_t  ev_a, ev_b, rd_ev;

  assign do_plug   = plug_req;
  assign do_unplug = unplug_req && !plug_req;
  assign do_err    = err_req && !plug_req && !unplug_req;
  assign do_cfg    = cfg_req && !plug_req && !unplug_req && !err_req;

  always_comb begin
    push_a = 1'b0;
    push_b = 1'b0;
    ev_a   = '0;
    ev_b   = '0;
    if (do_plug) begin
      push_a = 1'b1;
      push_b = 1'b1;
      ev_a = mk_event(CLS_AVAIL, EVC_ARRIVE, make_handle(32'(req_slot)), 32'(req_slot), '0, '0);
      ev_b = mk_event(CLS_AVAIL, EVC_ONLINE, make_handle(32'(req_slot)), 32'(req_slot), '0, '0);
    end else if (do_unplug) begin
      push_a = 1'b1;
      if (sel_cfg) begin
        push_b = 1'b1;
        ev_a = mk_event(CLS_AVAIL, EVC_GO_STANDBY, sel_hdl, sel_id, '0, '0);
        ev_b = mk_event(CLS_AVAIL, EVC_DEPART, sel_hdl, sel_id, '0, '0);
      end else begin
        ev_a = mk_event(CLS_AVAIL, EVC_DEPART, sel_hdl, sel_id, '0, '0);
      end
    end else if (do_err) begin
      push_a = 1'b1;
      ev_a = mk_event(CLS_ERROR, err_code, sel_hdl, sel_id, err_addr, err_qual);
    end
  end

  fhm_slot_table #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .plug_en    (do_plug),
    .unplug_en  (do_unplug),
    .cfg_en     (do_cfg),
    .slot_sel   (req_slot),
    .cfg_on     (cfg_on),
    .cfg_id     (cfg_id),
    .sel_hdl    (sel_hdl),
    .sel_id     (sel_id),
    .sel_cfg    (sel_cfg),
    .resp_vld   (cfg_resp_vld),
    .resp       (cfg_resp),
    .lk_id      (lk_id),
    .lk_id_hit  (lk_id_hit),
    .lk_id_slot (lk_id_slot),
    .lk_hdl     (lk_hdl),
    .lk_hdl_hit (lk_hdl_hit),
    .lk_hdl_slot(lk_hdl_slot),
    .lk_idx     (lk_idx),
    .lk_idx_hit (lk_idx_hit),
    .lk_idx_slot(lk_idx_slot)
  );

  fhm_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_a  (push_a),
    .ev_a    (ev_a),
    .push_b  (push_b),
    .ev_b    (ev_b),
    .pop     (pop_req),
    .rd_vld  (rd_vld),
    .rd_none (rd_none),
    .rd_ev   (rd_ev),
    .pending (pending),
    .overflow(overflow),
    .notify  (notify)
  );

  assign rd_class = rd_ev.cls;
  assign rd_code  = rd_ev.code;
  assign rd_hdl   = rd_ev.hdl;
  assign rd_id    = rd_ev.fn_id;
  assign rd_addr  = rd_ev.addr;
  assign rd_qual  = rd_ev.qual;

  AST_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cfg && !pending) |=> !pending); // R5
  AST_PLUG_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    plug_req |=> pending); // R2

endmodule

// File: tb/sim_fn_hotplug_mgr.sv
module sim_fn_hotplug_mgr;

  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic plug_req = 0, unplug_req = 0, err_req = 0, cfg_req = 0, cfg_on = 0, pop_req = 0;
  logic [SW-1:0] req_slot = '0, lk_idx = '0;
  logic [15:0] err_code = '0;
  logic [63:0] err_addr = '0;
  logic [31:0] err_qual = '0, cfg_id = '0, lk_id = '0, lk_hdl = '0;
  logic cfg_resp_vld, lk_id_hit, lk_hdl_hit, lk_idx_hit, rd_vld, rd_none, pending, overflow, notify;
  logic [15:0] cfg_resp, rd_code;
  logic [SW-1:0] lk_id_slot, lk_hdl_slot, lk_idx_slot;
  logic [7:0] rd_class;
  logic [31:0] rd_hdl, rd_id, rd_qual;
  logic [63:0] rd_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fn_hotplug_mgr #(.NUM_SLOTS(NS), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .plug_req(plug_req), .unplug_req(unplug_req), .err_req(err_req),
    .req_slot(req_slot), .err_code(err_code), .err_addr(err_addr), .err_qual(err_qual),
    .cfg_req(cfg_req), .cfg_on(cfg_on), .cfg_id(cfg_id), .cfg_resp_vld(cfg_resp_vld),
    .cfg_resp(cfg_resp), .lk_id(lk_id), .lk_id_hit(lk_id_hit), .lk_id_slot(lk_id_slot),
    .lk_hdl(lk_hdl), .lk_hdl_hit(lk_hdl_hit), .lk_hdl_slot(lk_hdl_slot), .lk_idx(lk_idx),
    .lk_idx_hit(lk_idx_hit), .lk_idx_slot(lk_idx_slot), .pop_req(pop_req), .rd_vld(rd_vld),
    .rd_none(rd_none), .rd_class(rd_class), .rd_code(rd_code), .rd_hdl(rd_hdl), .rd_id(rd_id),
    .rd_addr(rd_addr), .rd_qual(rd_qual), .pending(pending), .overflow(overflow), .notify(notify)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdl_of(input int s);
    return 32'h00FF_0000 + 32'(s);
  endfunction

  task automatic plug(input int s);
    @(negedge clk); plug_req = 1; req_slot = SW'(s);
    @(negedge clk); plug_req = 0;
  endtask

  task automatic unplug(input int s);
    @(negedge clk); unplug_req = 1; req_slot = SW'(s);
    @(negedge clk); unplug_req = 0;
  endtask

  task automatic raise_err(input int s, input logic [15:0] c, input logic [63:0] a, input logic [31:0] q);
    @(negedge clk); err_req = 1; req_slot = SW'(s); err_code = c; err_addr = a; err_qual = q;
    @(negedge clk); err_req = 0;
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] cls, input logic [15:0] code,
                            input logic [31:0] hdl, input logic [31:0] id,
                            input logic [63:0] addr, input logic [31:0] qual);
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0;
    chk({tag, " rd_vld"}, rd_vld, 1);
    chk({tag, " class"}, rd_class, cls);
    chk({tag, " code"}, rd_code, code);
    chk({tag, " handle"}, rd_hdl, hdl);
    chk({tag, " id"}, rd_id, id);
    chk({tag, " addr"}, rd_addr, addr);
    chk({tag, " qual"}, rd_qual, qual);
  endtask

  task automatic pop_empty(input string tag);
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0;
    chk({tag, " rd_none"}, rd_none, 1);
    chk({tag, " rd_vld"}, rd_vld, 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pop_req = 1;
    end
    @(negedge clk); pop_req = 0;
  endtask

  task automatic cfg_cmd(input string tag, input logic on, input logic [31:0] id, input logic [15:0] exp);
    @(negedge clk); cfg_req = 1; cfg_on = on; cfg_id = id;
    @(negedge clk); cfg_req = 0;
    chk({tag, " resp_vld"}, cfg_resp_vld, 1);
    chk({tag, " resp"}, cfg_resp, exp);
  endtask

  task automatic look_id(input string tag, input logic [31:0] id, input logic hit, input int s);
    lk_id = id; #1;
    chk({tag, " id hit"}, lk_id_hit, hit);
    if (hit) chk({tag, " id slot"}, lk_id_slot, s);
  endtask

  task automatic look_hdl(input string tag, input logic [31:0] h, input logic hit, input int s);
    lk_hdl = h; #1;
    chk({tag, " hdl hit"}, lk_hdl_hit, hit);
    if (hit) chk({tag, " hdl slot"}, lk_hdl_slot, s);
  endtask

  task automatic look_idx(input string tag, input int k, input logic hit, input int s);
    lk_idx = SW'(k); #1;
    chk({tag, " idx hit"}, lk_idx_hit, hit);
    if (hit) chk({tag, " idx slot"}, lk_idx_slot, s);
  endtask

  task automatic t_reset;
    chk("R6 reset pending", pending, 0);
    chk("R8 reset overflow", overflow, 0);
    chk("R7 reset notify", notify, 0);
    look_idx("R9 reset", 0, 0, 0);
  endtask

  task automatic t_plug;
    plug(2);
    chk("R7 notify after plug", notify, 1);
    chk("R6 pending after plug", pending, 1);
    look_id("R1", 2, 1, 2);
    look_hdl("R1", hdl_of(2), 1, 2);
    look_hdl("R9 other handle", hdl_of(3), 0, 0);
    pop_expect("R2 first", 2, 16'h0302, hdl_of(2), 2, 0, 0);
    chk("R7 notify clears", notify, 0);
    pop_expect("R2 second", 2, 16'h0301, hdl_of(2), 2, 0, 0);
    pop_empty("R6 empty pop");
    chk("R6 pending drained", pending, 0);
  endtask

  task automatic t_cfg;
    cfg_cmd("R5 configure configured", 1, 2, 16'h0020);
    cfg_cmd("R5 deconfigure", 0, 2, 16'h0010);
    cfg_cmd("R5 deconfigure again", 0, 2, 16'h0020);
    cfg_cmd("R5 unknown id", 1, 5, 16'h0030);
    chk("R5 no event queued", pending, 0);
  endtask

  task automatic t_unplug_unconfigured;
    unplug(2);
    pop_expect("R3 lone depart", 2, 16'h0308, hdl_of(2), 2, 0, 0);
    pop_empty("R3 single event");
    look_id("R3 cleared", 2, 0, 0);
  endtask

  task automatic t_unplug_configured;
    plug(1);
    drain(2);
    unplug(1);
    pop_expect("R3 standby", 2, 16'h0304, hdl_of(1), 1, 0, 0);
    pop_expect("R3 depart", 2, 16'h0308, hdl_of(1), 1, 0, 0);
    look_hdl("R3 cleared", hdl_of(1), 0, 0);
  endtask

  task automatic t_index;
    plug(0);
    plug(3);
    drain(4);
    look_idx("R9 rank0", 0, 1, 0);
    look_idx("R9 rank1", 1, 1, 3);
    look_idx("R9 rank2", 2, 0, 0);
    look_hdl("R9 slot0 handle", hdl_of(0), 1, 0);
    look_id("R9 id3", 3, 1, 3);
  endtask

  task automatic t_error;
    raise_err(3, 16'h000B, 64'h0000_1234_5678_9000, 32'h2);
    pop_expect("R4 error", 1, 16'h000B, hdl_of(3), 3, 64'h0000_1234_5678_9000, 32'h2);
  endtask

  task automatic t_priority;
    @(negedge clk); plug_req = 1; req_slot = 2'd1; cfg_req = 1; cfg_on = 0; cfg_id = 0;
    @(negedge clk); plug_req = 0; cfg_req = 0;
    chk("R10 cfg ignored", cfg_resp_vld, 0);
    pop_expect("R10 plug won", 2, 16'h0302, hdl_of(1), 1, 0, 0);
    drain(1);
    cfg_cmd("R10 slot0 still configured", 1, 0, 16'h0020);
  endtask

  task automatic t_overflow;
    chk("R8 no overflow yet", overflow, 0);
    raise_err(0, 16'h0001, 64'h10, 32'h0);
    raise_err(0, 16'h0002, 64'h20, 32'h0);
    raise_err(0, 16'h0003, 64'h30, 32'h0);
    chk("R8 not yet full", overflow, 0);
    unplug(1);
    chk("R8 overflow set", overflow, 1);
    pop_expect("R8 order1", 1, 16'h0001, hdl_of(0), 0, 64'h10, 0);
    pop_expect("R8 order2", 1, 16'h0002, hdl_of(0), 0, 64'h20, 0);
    pop_expect("R8 order3", 1, 16'h0003, hdl_of(0), 0, 64'h30, 0);
    pop_expect("R8 partial pair", 2, 16'h0304, hdl_of(1), 1, 0, 0);
    pop_empty("R8 second dropped");
    chk("R8 overflow sticky", overflow, 1);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plug();
    t_cfg();
    t_unplug_unconfigured();
    t_unplug_configured();
    t_index();
    t_error();
    t_priority();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule